// File: doc/BRIEF.md
# Bus Slave Termination Generator

This block is the target side of a shared, multi-drop external bus. It watches each address phase, marked by a one-cycle active-low transfer-start strobe, and compares the address with a window given by a base value and a mask. On a hit it takes the data-return and termination lines, inserts a chosen number of wait states, and acknowledges every data beat. For a burst it acknowledges all beats; for a single access it acknowledges one. A small register file stands in for the storage behind the slave.

The termination lines are active low. When nothing drives them, the board pulls them high. The block therefore gives an output enable for each line next to its value, and the lines are driven only between a decoded hit and the end of the access. A test-side error request can end the access with a transfer error in place of the acknowledge. The error is only ever placed on the first or the last beat of a burst. A burst-inhibit option makes the slave refuse bursts: it signals inhibit with the first acknowledge, and the access then ends after that one beat.

Top module: `bus_slave_term`

## Requirements
- R1: No output enable is high in the address-phase cycle (ts_n low). The enables rise only in the cycle after a start strobe whose address satisfies (addr & cfg_mask) == (cfg_base & cfg_mask).
- R2: A start strobe with a non-matching address leaves every output enable low for the whole access.
- R3: A single access (burst=0) gets exactly one acknowledge. A burst (burst=1) gets BEATS acknowledges. Beat b uses word index (addr[ADDR_LSB+:IDX_W] + b) mod DEPTH. On a read (rd_wr=1), rdata carries that word while rdata_oe is high. rdata_oe stays low on writes.
- R4: With cfg_wait = W, sampled at the start strobe, the acknowledge of beat b comes in cycle (W+1)*(b+1), counting the start-strobe cycle as cycle 0.
- R5: On a write, the word on wdata in an acknowledged beat's cycle is stored at that beat's index.
- R6: With cfg_inhibit=1, a burst request gets bi_n low together with the first acknowledge and ends after that single beat. A single access never gets bi_n low.
- R7: A beat chosen for the error gets tea_n low with ta_n held high. The access ends on that beat, and a write beat that ends in error stores nothing.
- R8: When err_req=1 at the start strobe, the error goes on beat 0 if err_beat is 0 or the access is one beat. Otherwise (intermediate or last beat) it goes on the last burst beat.
- R9: All output enables drop in the cycle right after the final acknowledge or the error.
- R10: While driven, each termination line sits at its inactive high level except in the cycle it signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_n | input | 1 | Transfer-start strobe, active low, one cycle |
| addr | input | AW (16) | Byte address of the access |
| rd_wr | input | 1 | 1 = read, 0 = write |
| burst | input | 1 | 1 = burst of BEATS beats requested |
| wdata | input | DW (32) | Write data from the master |
| cfg_base | input | AW | Address window base |
| cfg_mask | input | AW | Address bits compared against the base |
| cfg_wait | input | 3 | Wait states before each acknowledge |
| cfg_inhibit | input | 1 | Refuse bursts |
| err_req | input | 1 | Inject a transfer error in this access |
| err_beat | input | BEAT_W (2) | Requested beat for the error |
| ta_n | output | 1 | Transfer acknowledge, active low |
| ta_oe | output | 1 | Drive enable for ta_n |
| tea_n | output | 1 | Transfer error, active low |
| tea_oe | output | 1 | Drive enable for tea_n |
| bi_n | output | 1 | Burst inhibit, active low |
| bi_oe | output | 1 | Drive enable for bi_n |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
Single and burst accesses run with zero, one, two and three wait states. Each pattern pins down where every acknowledge falls and when the lines are released. A burst that starts near the top of the store shows whether the index wraps. A read of a non-matching address separates the decoder from the sequencer. Error requests on the first beat, on an intermediate beat and on a single access show whether errors are placed as required and whether an errored write leaves storage unchanged. Burst-inhibit runs with single and burst requests show that inhibit appears only when a burst is refused.

// File: rtl/bst_pkg.sv
package bst_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACT  = 1'b1
    } bst_state_e;

    // active-high termination strobes, inverted at the pins
    typedef struct packed {
        logic ack;
        logic err;
        logic inh;
    } bst_term_t;
endpackage

// File: rtl/bst_addr_decode.sv
module bst_addr_decode #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic          hit
);
    always_comb begin
        hit = ((addr & mask) == (base & mask));
    end
endmodule

// File: rtl/bst_err_slot.sv
module bst_err_slot #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              req,
    input  logic [BEAT_W-1:0] want,
    input  logic              multi,
    output logic              en,
    output logic [BEAT_W-1:0] slot
);
    localparam logic [BEAT_W-1:0] LastBeat = BEAT_W'(BEATS - 1);

    always_comb begin
        en = req;
        if (!multi || want == '0) begin
            slot = '0;
        end else begin
            slot = LastBeat;
        end
    end
endmodule

// File: rtl/bst_reg_file.sv
module bst_reg_file #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[idx];
    end
endmodule

// File: rtl/bst_beat_ctrl.sv
module bst_beat_ctrl
    import bst_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int IW     = 4,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_n,
    input  logic              hit,
    input  logic              rd_wr,
    input  logic              burst,
    input  logic [2:0]        cfg_wait,
    input  logic              cfg_inhibit,
    input  logic              err_en,
    input  logic [BEAT_W-1:0] err_slot,
    input  logic [IW-1:0]     start_idx,
    output logic              multi_req,
    output logic              active,
    output logic              is_read,
    output bst_term_t         term,
    output logic              wr_en,
    output logic [IW-1:0]     cur_idx
);
    localparam logic [BEAT_W-1:0] LastBeat = BEAT_W'(BEATS - 1);

    typedef struct packed {
        bst_state_e        st;
        logic              rd;
        logic              multi;
        logic              inh;
        logic [2:0]        wcfg;
        logic [2:0]        wcnt;
        logic [BEAT_W-1:0] beat;
        logic              err_en;
        logic [BEAT_W-1:0] err_at;
        logic [IW-1:0]     idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ack_now, err_now, last_beat;

    // burst honoured only when not inhibited
    assign multi_req = burst && !cfg_inhibit;

    always_comb begin
        ctl_d     = ctl_q;
        ack_now   = (ctl_q.st == ST_ACT) && (ctl_q.wcnt == '0);
        err_now   = ack_now && ctl_q.err_en && (ctl_q.beat == ctl_q.err_at);
        last_beat = !ctl_q.multi || (ctl_q.beat == LastBeat);

        term.ack = ack_now && !err_now;
        term.err = err_now;
        term.inh = ack_now && !err_now && ctl_q.inh;

        if (ctl_q.st == ST_IDLE) begin
            if (!ts_n && hit) begin
                ctl_d.st     = ST_ACT;
                ctl_d.rd     = rd_wr;
                ctl_d.multi  = multi_req;
                ctl_d.inh    = burst && cfg_inhibit;
                ctl_d.wcfg   = cfg_wait;
                ctl_d.wcnt   = cfg_wait;
                ctl_d.beat   = '0;
                ctl_d.err_en = err_en;
                ctl_d.err_at = err_slot;
                ctl_d.idx    = start_idx;
            end
        end else if (ack_now) begin
            if (err_now || last_beat) begin
                ctl_d.st     = ST_IDLE;
                ctl_d.err_en = 1'b0;
            end else begin
                ctl_d.beat = ctl_q.beat + 1'b1;
                ctl_d.wcnt = ctl_q.wcfg;
            end
        end else begin
            ctl_d.wcnt = ctl_q.wcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active  = (ctl_q.st == ST_ACT);
    assign is_read = ctl_q.rd;
    assign wr_en   = term.ack && !ctl_q.rd;
    assign cur_idx = ctl_q.idx + IW'(ctl_q.beat);
endmodule

// File: rtl/bus_slave_term.sv
module bus_slave_term
    import bst_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int DEPTH    = 16,
    parameter int BEATS    = 4,
    parameter int ADDR_LSB = 2,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd_wr,
    input  logic              burst,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-1:0]     cfg_base,
    input  logic [AW-1:0]     cfg_mask,
    input  logic [2:0]        cfg_wait,
    input  logic              cfg_inhibit,
    input  logic              err_req,
    input  logic [BEAT_W-1:0] err_beat,
    output logic              ta_n,
    output logic              ta_oe,
    output logic              tea_n,
    output logic              tea_oe,
    output logic              bi_n,
    output logic              bi_oe,
    output logic [DW-1:0]     rdata,
    output logic              rdata_oe
);
    logic              hit;
    logic              multi_req;
    logic              err_en;
    logic [BEAT_W-1:0] err_slot;
    logic              active;
    logic              is_read;
    bst_term_t         term;
    logic              wr_en;
    logic [IDX_W-1:0]  cur_idx;
    logic [DW-1:0]     mem_rd;

    bst_addr_decode #(.AW(AW)) u_dec (
        .addr (addr),
        .base (cfg_base),
        .mask (cfg_mask),
        .hit  (hit)
    );

    bst_err_slot #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_err (
        .req   (err_req),
        .want  (err_beat),
        .multi (multi_req),
        .en    (err_en),
        .slot  (err_slot)
    );

    bst_beat_ctrl #(.BEATS(BEATS), .IW(IDX_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ts_n        (ts_n),
        .hit         (hit),
        .rd_wr       (rd_wr),
        .burst       (burst),
        .cfg_wait    (cfg_wait),
        .cfg_inhibit (cfg_inhibit),
        .err_en      (err_en),
        .err_slot    (err_slot),
        .start_idx   (addr[ADDR_LSB +: IDX_W]),
        .multi_req   (multi_req),
        .active      (active),
        .is_read     (is_read),
        .term        (term),
        .wr_en       (wr_en),
        .cur_idx     (cur_idx)
    );

    bst_reg_file #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .idx   (cur_idx),
        .wdata (wdata),
        .rdata (mem_rd)
    );

    // pins: enables follow ownership, levels idle high
    always_comb begin
        ta_oe    = active;
        tea_oe   = active;
        bi_oe    = active;
        ta_n     = !term.ack;
        tea_n    = !term.err;
        bi_n     = !term.inh;
        rdata_oe = active && is_read;
        rdata    = rdata_oe ? mem_rd : '0;
    end
endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ts_n,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_mask,
    input logic          ta_n,
    input logic          ta_oe,
    input logic          tea_n,
    input logic          tea_oe,
    input logic          bi_n,
    input logic          bi_oe,
    input logic          rdata_oe
);
    // R1
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ta_oe) |-> $past(!ts_n && ((addr & cfg_mask) == (cfg_base & cfg_mask))));

    // R7
    error_over_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tea_oe && !tea_n) |-> ta_n);

    // R6
    inhibit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bi_oe && !bi_n) |-> (ta_oe && !ta_n));

    // R9
    release_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tea_oe && !tea_n) || (bi_oe && !bi_n)) |=> (!ta_oe && !tea_oe && !bi_oe && !rdata_oe));

    // R3
    data_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> ta_oe);
endmodule

bind bus_slave_term bst_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts_n     (ts_n),
    .addr     (addr),
    .cfg_base (cfg_base),
    .cfg_mask (cfg_mask),
    .ta_n     (ta_n),
    .ta_oe    (ta_oe),
    .tea_n    (tea_n),
    .tea_oe   (tea_oe),
    .bi_n     (bi_n),
    .bi_oe    (bi_oe),
    .rdata_oe (rdata_oe)
);

// File: tb/bus_slave_term_test.sv
`timescale 1ns/1ps
module bus_slave_term_test;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ts_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_wr = 1'b1;
    logic          burst = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] cfg_base = 16'h4000;
    logic [AW-1:0] cfg_mask = 16'hF000;
    logic [2:0]    cfg_wait = '0;
    logic          cfg_inhibit = 1'b0;
    logic          err_req = 1'b0;
    logic [1:0]    err_beat = '0;
    logic          ta_n, ta_oe, tea_n, tea_oe, bi_n, bi_oe, rdata_oe;
    logic [DW-1:0] rdata;

    // pulled-up shared lines
    wire ta_bus  = ta_oe  ? ta_n  : 1'b1;
    wire tea_bus = tea_oe ? tea_n : 1'b1;
    wire bi_bus  = bi_oe  ? bi_n  : 1'b1;

    bus_slave_term uut (
        .clk(clk), .rst_n(rst_n), .ts_n(ts_n), .addr(addr), .rd_wr(rd_wr),
        .burst(burst), .wdata(wdata), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_wait(cfg_wait), .cfg_inhibit(cfg_inhibit), .err_req(err_req),
        .err_beat(err_beat), .ta_n(ta_n), .ta_oe(ta_oe), .tea_n(tea_n),
        .tea_oe(tea_oe), .bi_n(bi_n), .bi_oe(bi_oe), .rdata(rdata),
        .rdata_oe(rdata_oe)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] model [16];
    logic [DW-1:0] wbuf [4];
    int            ack_cyc [8];
    logic [DW-1:0] ack_dat [8];
    int            n_ack, err_cyc, bi_cyc, last_oe, oe_ts, anomalies, rd_oe_bad;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // issue one access and record what the bus shows, cycle by cycle
    task automatic run(input logic [AW-1:0] a, input bit rd, input bit bst, input int w,
                       input bit er, input int eb);
        n_ack = 0; err_cyc = -1; bi_cyc = -1; last_oe = -1; anomalies = 0; rd_oe_bad = 0;
        @(negedge clk);
        addr = a; rd_wr = rd; burst = bst; cfg_wait = 3'(w);
        err_req = er; err_beat = 2'(eb); ts_n = 1'b0; wdata = wbuf[0];
        oe_ts = int'(ta_oe | tea_oe | bi_oe | rdata_oe);
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            ts_n = 1'b1; err_req = 1'b0;
            wdata = wbuf[n_ack < 4 ? n_ack : 3];
            if (ta_oe || tea_oe || bi_oe || rdata_oe) last_oe = c;
            if (rdata_oe != (ta_oe && rd)) rd_oe_bad++;
            if (!bi_bus && ta_bus) anomalies++;
            if (!tea_bus && !ta_bus) anomalies++;
            if (!bi_bus) bi_cyc = c;
            if (!tea_bus) err_cyc = c;
            if (!ta_bus) begin
                if (n_ack < 8) begin
                    ack_cyc[n_ack] = c;
                    ack_dat[n_ack] = rdata;
                end
                n_ack++;
            end
        end
        chk(oe_ts == 0, "R1 enables in address phase", oe_ts, 0);
        chk(anomalies == 0, "R10 idle levels", anomalies, 0);
        chk(rd_oe_bad == 0, "R3 rdata_oe vs direction", rd_oe_bad, 0);
    endtask

    task automatic t_reset();
        chk(!ta_oe && !tea_oe && !bi_oe && !rdata_oe, "R1 reset enables",
            {ta_oe, tea_oe, bi_oe, rdata_oe}, 0);
    endtask

    task automatic t_nomatch();
        run(16'h5010, 1'b1, 1'b0, 0, 1'b0, 0);
        chk(last_oe == -1, "R2 miss drives nothing", last_oe, -1);
        chk(n_ack == 0, "R2 miss no ack", n_ack, 0);
    endtask

    task automatic t_single();
        wbuf[0] = 32'hA5A5_0102;
        run(16'h4008, 1'b0, 1'b0, 0, 1'b0, 0);
        model[2] = wbuf[0];
        chk(n_ack == 1 && ack_cyc[0] == 1, "R4 single write ack cycle", ack_cyc[0], 1);
        chk(last_oe == 1, "R9 release after single", last_oe, 1);
        chk(bi_cyc == -1 && err_cyc == -1, "R6 no inhibit on single", bi_cyc, -1);
        run(16'h4008, 1'b1, 1'b0, 3, 1'b0, 0);
        chk(n_ack == 1 && ack_cyc[0] == 4, "R4 single read three waits", ack_cyc[0], 4);
        chk(ack_dat[0] == model[2], "R5 single readback", ack_dat[0], model[2]);
    endtask

    task automatic t_burst(input logic [AW-1:0] a, input int base, input int w);
        for (int i = 0; i < 4; i++) wbuf[i] = 32'h1000_0000 * (i + 1) + 32'(a) + 32'(w);
        run(a, 1'b0, 1'b1, w, 1'b0, 0);
        for (int i = 0; i < 4; i++) model[(base + i) % 16] = wbuf[i];
        chk(n_ack == 4, "R3 burst beat count", n_ack, 4);
        for (int i = 0; i < 4; i++)
            chk(ack_cyc[i] == (w + 1) * (i + 1), "R4 burst ack spacing", ack_cyc[i], (w + 1) * (i + 1));
        chk(last_oe == 4 * (w + 1), "R9 release after burst", last_oe, 4 * (w + 1));
        run(a, 1'b1, 1'b1, 0, 1'b0, 0);
        for (int i = 0; i < 4; i++)
            chk(ack_dat[i] == model[(base + i) % 16], "R5 burst readback with index wrap",
                ack_dat[i], model[(base + i) % 16]);
    endtask

    task automatic t_inhibit();
        cfg_inhibit = 1'b1;
        run(16'h4010, 1'b1, 1'b1, 1, 1'b0, 0);
        chk(n_ack == 1 && ack_cyc[0] == 2, "R6 inhibited burst one beat", n_ack, 1);
        chk(bi_cyc == 2, "R6 inhibit with first ack", bi_cyc, 2);
        chk(ack_dat[0] == model[4], "R3 inhibited beat data", ack_dat[0], model[4]);
        chk(last_oe == 2, "R9 release after inhibit", last_oe, 2);
        run(16'h4010, 1'b1, 1'b0, 0, 1'b0, 0);
        chk(bi_cyc == -1 && n_ack == 1, "R6 single not inhibited", bi_cyc, -1);
        cfg_inhibit = 1'b0;
    endtask

    task automatic t_err_mid();
        for (int i = 0; i < 4; i++) wbuf[i] = 32'hE000_0000 + 32'(i);
        run(16'h4020, 1'b0, 1'b1, 2, 1'b1, 1);
        for (int i = 0; i < 3; i++) model[8 + i] = wbuf[i];
        chk(n_ack == 3, "R8 intermediate error moved to last", n_ack, 3);
        chk(err_cyc == 12, "R8 error on last beat cycle", err_cyc, 12);
        chk(last_oe == 12, "R9 release after error", last_oe, 12);
        run(16'h4020, 1'b1, 1'b1, 0, 1'b0, 0);
        chk(ack_dat[3] == model[11], "R7 errored beat not written", ack_dat[3], model[11]);
        chk(ack_dat[2] == model[10], "R5 beats before error written", ack_dat[2], model[10]);
    endtask

    task automatic t_err_first();
        run(16'h4010, 1'b1, 1'b1, 0, 1'b1, 0);
        chk(n_ack == 0 && err_cyc == 1, "R7 error on first beat", err_cyc, 1);
        chk(last_oe == 1, "R9 release after first-beat error", last_oe, 1);
    endtask

    task automatic t_err_single();
        wbuf[0] = 32'hDEAD_0001;
        run(16'h4008, 1'b0, 1'b0, 1, 1'b1, 2);
        chk(n_ack == 0 && err_cyc == 2, "R8 single access error on its beat", err_cyc, 2);
        run(16'h4008, 1'b1, 1'b0, 0, 1'b0, 0);
        chk(ack_dat[0] == model[2], "R7 errored single write dropped", ack_dat[0], model[2]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 4; i++) wbuf[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nomatch();
        t_single();
        t_burst(16'h4010, 4, 2);
        t_burst(16'h4038, 14, 0);
        t_inhibit();
        t_err_mid();
        t_err_first();
        t_err_single();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule